// File: doc/BRIEF.md
# Overcurrent Fault Counter with Hiccup Restart

This block keeps the overcurrent record of a synchronous buck controller, one switching cycle at a time. On each cycle strobe it reads two sense flags: high-side overcurrent and low-side valley overcurrent. A cycle with either flag raised adds one to a saturating fault count. A clean cycle takes one away, and the count never goes below zero. When the count reaches the trip value, the block declares a fault and inhibits switching. It then lets the soft-start timer run a number of dummy timeouts before it asks for a real soft-start.

The number of dummy timeouts depends on when the fault arose. A fault tripped while the controller reports initial startup waits through one more dummy timeout than a fault tripped in normal operation. When the last dummy timeout arrives, the block does four things at once: it clears the fault, drops the inhibit, clears the count and issues a one-cycle restart request. A fault that comes back starts the hiccup again, with no limit on repeats.

A high-side overcurrent also cuts the present high-side pulse through a combinational path, which gives pulse-by-pulse limiting. A protection-disable input masks both sense flags. All pins are plain control and status levels or pulses. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `oc_hiccup_ctrl`

## Requirements
- R1: On a rising clock edge with `cyc_strobe` high, protection enabled and no fault, a raised `hs_oc` or `ls_oc` (either one or both) raises the fault count by one.
- R2: A strobed cycle with neither flag raised lowers the count by one. The count stays at zero when already zero, so trip needs three net overcurrent cycles after any run of clean cycles.
- R3: The edge on which the count reaches TRIP_COUNT (default 3) drives `fault` and `sw_inhibit` high, and drives `ss_real` low, from the following cycle.
- R4: For a fault tripped with `in_startup` low, the fourth `ss_timeout` pulse after the trip clears `fault` and `sw_inhibit`, raises `ss_real`, and gives `ss_restart` high for exactly one cycle. The first three pulses leave the fault set.
- R5: For a fault tripped with `in_startup` high, the restart comes on the fifth `ss_timeout` pulse. After the fourth pulse `fault` is still high.
- R6: The restart clears the fault count, so a new fault needs TRIP_COUNT fresh overcurrent cycles. The hiccup cycle repeats every time the fault recurs.
- R7: `hs_cutoff` follows `hs_oc` in the same cycle, with no register, while protection is enabled.
- R8: While `oc_disable` is high, both flags have no effect: `hs_cutoff` stays low, and strobed cycles count as clean cycles.
- R9: During a fault, strobes and sense flags leave the count unchanged. Outside a fault, `ss_timeout` pulses have no effect.
- R10: After reset, `fault`, `sw_inhibit` and `ss_restart` are low and `ss_real` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_strobe | input | 1 | One pulse per switching cycle; flags are sampled with it |
| hs_oc | input | 1 | High-side overcurrent sense flag |
| ls_oc | input | 1 | Low-side valley overcurrent sense flag |
| ss_timeout | input | 1 | Soft-start timer completion pulse |
| in_startup | input | 1 | High while the controller is in initial startup |
| oc_disable | input | 1 | Masks both overcurrent flags |
| fault | output | 1 | Overcurrent fault declared |
| sw_inhibit | output | 1 | Switching held off during hiccup |
| ss_real | output | 1 | High: current soft-start is real; low: dummy |
| ss_restart | output | 1 | One-cycle request to start a real soft-start |
| hs_cutoff | output | 1 | Immediate termination of the present high-side pulse |

## Verification
No port shows the fault count directly. A count that is off by one shows up as `fault` rising one strobe early or one strobe late. A floor that wraps instead of holding at zero shows up as a trip after a long clean run. A wrong dummy target, or a timeout counter that was never reset, moves the `ss_restart` pulse by one `ss_timeout` pulse, and the bench counts those pulses exactly for both startup and normal faults. A randomized run checks every output against a requirement model after every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/oc_hiccup_pkg.sv
package oc_hiccup_pkg;
  typedef enum logic {
    HS_RUN    = 1'b0,
    HS_HICCUP = 1'b1
  } hic_state_e;
endpackage

// File: rtl/oc_fault_counter.sv
module oc_fault_counter #(
  parameter int TRIP_COUNT = 3,
  parameter int CW = $clog2(TRIP_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          oc,
  input  logic          clr,
  output logic          trip,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TRIP_V = CW'(TRIP_COUNT);
  localparam logic [CW-1:0] LAST_V = CW'(TRIP_COUNT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      if (oc) begin
        if (cnt_q != TRIP_V) cnt_d = cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trip  = en & oc & (cnt_q == LAST_V);
  assign count = cnt_q;
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import oc_hiccup_pkg::*;
#(
  parameter int DUMMY_RUN   = 4,
  parameter int DUMMY_START = 5,
  parameter int TW = $clog2(((DUMMY_RUN > DUMMY_START) ? DUMMY_RUN : DUMMY_START) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip,
  input  logic          in_startup,
  input  logic          ss_timeout,
  output logic          in_hiccup,
  output logic          done,
  output logic          restart_pulse,
  output logic [TW-1:0] tmo_count
);
  localparam logic [TW-1:0] RUN_V   = TW'(DUMMY_RUN);
  localparam logic [TW-1:0] START_V = TW'(DUMMY_START);

  hic_state_e    state_q;
  logic [TW-1:0] tmo_q, tgt_q;
  logic          rst_pulse_q;

  assign done = (state_q == HS_HICCUP) & ss_timeout & ((tmo_q + 1'b1) == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= HS_RUN;
      tmo_q       <= '0;
      tgt_q       <= RUN_V;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= 1'b0;
      case (state_q)
        HS_RUN: begin
          if (trip) begin
            state_q <= HS_HICCUP;
            tmo_q   <= '0;
            tgt_q   <= in_startup ? START_V : RUN_V;
          end
        end
        default: begin
          if (done) begin
            state_q     <= HS_RUN;
            tmo_q       <= '0;
            rst_pulse_q <= 1'b1;
          end else if (ss_timeout) begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign in_hiccup     = (state_q == HS_HICCUP);
  assign restart_pulse = rst_pulse_q;
  assign tmo_count     = tmo_q;
endmodule

// File: rtl/oc_hiccup_ctrl.sv
module oc_hiccup_ctrl #(
  parameter int TRIP_COUNT  = 3,
  parameter int DUMMY_RUN   = 4,
  parameter int DUMMY_START = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_strobe,
  input  logic hs_oc,
  input  logic ls_oc,
  input  logic ss_timeout,
  input  logic in_startup,
  input  logic oc_disable,
  output logic fault,
  output logic sw_inhibit,
  output logic ss_real,
  output logic ss_restart,
  output logic hs_cutoff
);
  localparam int CNT_W = $clog2(TRIP_COUNT + 1);
  localparam int TMO_W = $clog2(((DUMMY_RUN > DUMMY_START) ? DUMMY_RUN : DUMMY_START) + 1);

  logic             hic_w, done_w, trip_w, rstp_w, oc_w, en_w;
  logic [CNT_W-1:0] cnt_w;
  logic [TMO_W-1:0] tmo_w;

  assign oc_w = (hs_oc | ls_oc) & ~oc_disable;
  assign en_w = cyc_strobe & ~hic_w;

  oc_fault_counter #(.TRIP_COUNT(TRIP_COUNT), .CW(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_w),
    .oc    (oc_w),
    .clr   (done_w),
    .trip  (trip_w),
    .count (cnt_w)
  );

  hiccup_seq #(.DUMMY_RUN(DUMMY_RUN), .DUMMY_START(DUMMY_START), .TW(TMO_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .trip          (trip_w),
    .in_startup    (in_startup),
    .ss_timeout    (ss_timeout),
    .in_hiccup     (hic_w),
    .done          (done_w),
    .restart_pulse (rstp_w),
    .tmo_count     (tmo_w)
  );

  assign fault      = hic_w;
  assign sw_inhibit = hic_w;
  assign ss_real    = ~hic_w;
  assign ss_restart = rstp_w;
  assign hs_cutoff  = hs_oc & ~oc_disable;
endmodule

// File: rtl/oc_hiccup_chk.sv
module oc_hiccup_chk #(
  parameter int TRIP_COUNT = 3,
  parameter int CW = 2,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_strobe,
  input logic          hs_oc,
  input logic          ls_oc,
  input logic          oc_disable,
  input logic          ss_timeout,
  input logic          fault,
  input logic          ss_restart,
  input logic [CW-1:0] cnt,
  input logic [TW-1:0] tmo
);
  localparam logic [CW-1:0] TRIP_V = CW'(TRIP_COUNT);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TRIP_V);

  assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !fault && !oc_disable && (hs_oc || ls_oc) && cnt < TRIP_V)
    |=> (cnt == $past(cnt) + 1'b1));

  assert_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !fault && cnt == '0 && !(hs_oc || ls_oc)) |=> (cnt == '0));

  assert_trip_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(cyc_strobe));

  assert_restart_after_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_restart) |-> ($past(ss_timeout) && $past(fault)));

  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> (cnt == '0 && !fault && tmo == '0));

  assert_disable_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && oc_disable && !fault && cnt == '0) |=> !fault);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!fault || $stable(cnt)));
endmodule

bind oc_hiccup_ctrl oc_hiccup_chk #(.TRIP_COUNT(TRIP_COUNT), .CW(CNT_W), .TW(TMO_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_strobe (cyc_strobe),
  .hs_oc      (hs_oc),
  .ls_oc      (ls_oc),
  .oc_disable (oc_disable),
  .ss_timeout (ss_timeout),
  .fault      (fault),
  .ss_restart (ss_restart),
  .cnt        (cnt_w),
  .tmo        (tmo_w)
);

// File: tb/oc_hiccup_ctrl_tb_top.sv
`timescale 1ns/1ps
module oc_hiccup_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_strobe = 1'b0, hs_oc = 1'b0, ls_oc = 1'b0, ss_timeout = 1'b0;
  logic in_startup = 1'b0, oc_disable = 1'b0;
  logic fault, sw_inhibit, ss_real, ss_restart, hs_cutoff;

  int checks = 0;
  int errors = 0;

  int m_cnt = 0, m_tmo = 0, m_tgt = 4;
  bit m_hic = 1'b0, m_rst = 1'b0;

  always #2.5 clk = ~clk;

  oc_hiccup_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .hs_oc(hs_oc), .ls_oc(ls_oc),
    .ss_timeout(ss_timeout), .in_startup(in_startup), .oc_disable(oc_disable),
    .fault(fault), .sw_inhibit(sw_inhibit), .ss_real(ss_real), .ss_restart(ss_restart),
    .hs_cutoff(hs_cutoff)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step(bit s, bit h, bit l, bit d, bit t, bit st);
    m_rst = 1'b0;
    if (!m_hic) begin
      if (s) begin
        if (!d && (h || l)) begin
          if (m_cnt < 3) m_cnt++;
        end else if (m_cnt > 0) m_cnt--;
        if (m_cnt == 3) begin
          m_hic = 1'b1; m_tmo = 0; m_tgt = st ? 5 : 4;
        end
      end
    end else if (t) begin
      m_tmo++;
      if (m_tmo == m_tgt) begin
        m_hic = 1'b0; m_rst = 1'b1; m_cnt = 0;
      end
    end
  endfunction

  task automatic drive(bit s, bit h, bit l, bit d, bit t, bit st);
    @(negedge clk);
    chk("R3 fault", fault, m_hic);
    chk("R3 sw_inhibit", sw_inhibit, m_hic);
    chk("R4 ss_real", ss_real, !m_hic);
    chk("R4 ss_restart", ss_restart, m_rst);
    cyc_strobe = s; hs_oc = h; ls_oc = l; oc_disable = d; ss_timeout = t; in_startup = st;
    #1;
    chk(d ? "R8 hs_cutoff" : "R7 hs_cutoff", hs_cutoff, h && !d);
    model_step(s, h, l, d, t, st);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic exit_hiccup(int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 1, 0);
      if (i < n - 1) begin
        chk("R4 fault held", fault, 1);
        idle(1);
      end
    end
    chk("R4 restart", ss_restart, 1);
    chk("R4 fault cleared", fault, 0);
    idle(1);
    chk("R4 restart single", ss_restart, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    chk("R10 fault", fault, 0);
    chk("R10 ss_real", ss_real, 1);
    chk("R10 ss_restart", ss_restart, 0);

    // R1 R3: either flag counts; third trips
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0);
    chk("R1 no trip at two", fault, 0);
    drive(1, 1, 1, 0, 0, 0);
    chk("R3 trip", fault, 1);
    chk("R3 inhibit", sw_inhibit, 1);
    chk("R3 dummy marker", ss_real, 0);
    // R9: strobes ignored in hiccup, timeout counts
    drive(1, 1, 1, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0);
    exit_hiccup(4);

    // R6: count cleared after restart; R9 frozen count
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    chk("R6 cleared count", fault, 0);
    drive(1, 1, 0, 0, 0, 0);
    chk("R6 retrip", fault, 1);
    exit_hiccup(4);

    // R2: down count
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    chk("R2 decrement", fault, 0);
    drive(1, 1, 0, 0, 0, 0);
    chk("R2 trip after net three", fault, 1);
    exit_hiccup(4);

    // R2 floor, R9 timeout ignored outside fault
    for (int i = 0; i < 6; i++) drive(1, 0, 0, 0, 1, 0);
    drive(1, 0, 1, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0);
    chk("R2 floor", fault, 0);
    drive(1, 0, 1, 0, 0, 1);
    chk("R5 trip in startup", fault, 1);
    exit_hiccup(5);

    // R8 disable
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 1, 0, 0);
    chk("R8 disabled no fault", fault, 0);
    drive(1, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0);
    chk("R8 count stayed clean", fault, 0);
    idle(3);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      drive(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
            ($urandom % 16) == 0, ($urandom % 3) == 0, ($urandom % 2) == 1);
    end
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule